// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on three input pins. It runs a 16-bit free-running count behind a selectable prescaler. Each pin passes through a two-flop synchronizer and is then compared with its last stored level. When a pin changes in the direction its 2-bit edge selector asks for, the current count is copied into that pin's capture register. The pin's flag bit is set at the same edge, and an interrupt request is raised if that channel is enabled.

Channels are numbered in the reverse of the pin order. Pin bit 2 is channel 1 and pin bit 0 is channel 3. Software reads each channel as a pair of bytes through a small read port.

Every pin of the block is a plain control or status signal. No data stream crosses its boundary, so there is no valid/ready handshake and no back-pressure. Reads are combinational. A flag-clear write takes effect at the next clock edge.

Top module: `icu_capture_top`

## Requirements
- R1: A pin change applied just after a clock edge has not set a flag after the second following rising edge. It has set the flag after the third following rising edge (two synchronizer stages, then detection).
- R2: `edge_ctl[2i+1:2i]` selects the capture condition for pin bit i. Code 0 never captures. Code 1 captures on 0→1. Code 2 captures on 1→0. Code 3 captures on either change. A level that is held never captures.
- R3: Pin bit i feeds channel 3−i. Read address 2(c−1) returns the high byte of channel c, and address 2(c−1)+1 returns its low byte. Addresses 6 and 7 read 0.
- R4: A capture register takes the value `tcnt` showed during the cycle just before its flag rises. It keeps that value until the next capture on the same channel.
- R5: A capture sets `flags[i]` at the pin's bit position. The flag stays set until it is cleared.
- R6: While `flag_clr_we` is high, each 1 in `flag_clr_data` clears the matching flag at the next edge. Bits written as 0 are left alone. A capture at the same edge leaves the flag set.
- R7: `irq` is high exactly when some i has `flags[i]` and `irq_en[i]` both set.
- R8: `presc_sel` codes 0, 1, 2 and 3 make `tcnt` advance once every 1, 4, 8 and 16 cycles respectively.
- R9: `tcnt` wraps from 0xFFFF to 0x0000.
- R10: Reset clears `tcnt`, the flags, the capture registers and the stored pin levels. A pin held high through reset is therefore seen as a rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 3 | Unsynchronized capture pins |
| edge_ctl | input | 8 | Edge selectors, 2 bits per pin bit; bits 7:6 unused |
| presc_sel | input | 2 | Prescaler code |
| irq_en | input | 3 | Interrupt enable per pin bit |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_data | input | 3 | Write-one-to-clear mask |
| rd_addr | input | 3 | Capture byte address |
| rd_data | output | 8 | Capture byte read data |
| flags | output | 3 | Capture flags, bit i belongs to pin bit i |
| irq | output | 1 | Interrupt request |
| tcnt | output | 16 | Free-running count |

## Verification
The embedded assertions watch several rules on every cycle:
- a flag holds until cleared;
- a capture beats a clear at the same edge;
- a channel whose selector is off never raises its flag;
- capture registers change only on a capture;
- the count moves only on a prescaler tick and wraps to zero.

Other behaviours can only be shown by the bench's scenarios: the exact three-edge latency, the captured timestamp value, the reversed channel numbering, the byte order, the prescaler rates and the rising edge seen after reset. The bench sweeps every pin bit, every edge code and both directions.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  localparam int unsigned PS_W = 4;

  // divide-by value minus one for each prescaler code
  function automatic logic [PS_W-1:0] presc_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd3;
      2'd2:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/icu_timebase.sv
module icu_timebase
  import icu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       presc_sel,
  output logic [CNT_W-1:0] count_o
);

  logic [PS_W-1:0]  ps_q;
  logic [PS_W-1:0]  ps_lim;
  logic [CNT_W-1:0] count_q;
  logic             tick;

  assign ps_lim = presc_limit(presc_sel);
  // ">=" recovers at once when the divide ratio shrinks on the fly
  assign tick   = (ps_q >= ps_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      count_q <= '0;
    end else begin
      ps_q <= tick ? '0 : ps_q + 1'b1;
      if (tick) count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q == '1) |=> (count_q == '0));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));

endmodule

// File: rtl/icu_channel.sv
module icu_channel
  import icu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  edge_sel_e        sel_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [CNT_W-1:0] cap_o
);

  logic             prev_q;
  logic             flag_q;
  logic [CNT_W-1:0] cap_q;
  logic             changed;
  logic             hit;

  assign changed = pin_i ^ prev_q;

  always_comb begin
    hit = 1'b0;
    if (changed) begin
      case (sel_i)
        EDGE_RISE: hit = pin_i;
        EDGE_FALL: hit = !pin_i;
        EDGE_ANY:  hit = 1'b1;
        default:   hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      prev_q <= pin_i;
      if (hit) begin
        flag_q <= 1'b1;
        cap_q  <= count_i;
      end else if (clr_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;
  assign cap_o  = cap_q;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R6
  cap_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_i) |=> flag_q);

  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_i && !hit) |=> !flag_q);

  // R4
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == EDGE_OFF && !flag_q) |=> !flag_q);

endmodule

// File: rtl/icu_capture_top.sv
module icu_capture_top
  import icu_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CTL_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_async,
  input  logic [CTL_W-1:0]  edge_ctl,
  input  logic [1:0]        presc_sel,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic              flag_clr_we,
  input  logic [NUM_CH-1:0] flag_clr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_CH-1:0] flags,
  output logic              irq,
  output logic [15:0]       tcnt
);

  localparam int unsigned CNT_W   = 16;
  localparam int unsigned SEL_USE = 2 * NUM_CH;

  logic [NUM_CH-1:0] pin_s;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap [NUM_CH];

  generate
    if (CTL_W > SEL_USE) begin : g_spare
      logic unused_ctl;
      assign unused_ctl = ^edge_ctl[CTL_W-1:SEL_USE];
    end
  endgenerate

  icu_sync #(.WIDTH(NUM_CH)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_async),
    .q_o   (pin_s)
  );

  icu_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_sel (presc_sel),
    .count_o   (count)
  );

  for (genvar b = 0; b < NUM_CH; b++) begin : g_ch
    icu_channel #(.CNT_W(CNT_W)) ch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_s[b]),
      .sel_i   (edge_sel_e'(edge_ctl[2*b +: 2])),
      .count_i (count),
      .clr_i   (flag_clr_we & flag_clr_data[b]),
      .flag_o  (flags[b]),
      .cap_o   (cap[b])
    );
  end

  // channel c = NUM_CH - b; high byte at the even address
  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_CH; b++) begin
      if (rd_addr == ADDR_W'(2 * (NUM_CH - 1 - b)))
        rd_data = cap[b][15:8];
      if (rd_addr == ADDR_W'(2 * (NUM_CH - 1 - b) + 1))
        rd_data = cap[b][7:0];
    end
  end

  assign irq  = |(flags & irq_en);
  assign tcnt = count;

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);

endmodule

// File: tb/icu_capture_top_tb_top.sv
module icu_capture_top_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  pin_async;
  logic [7:0]  edge_ctl;
  logic [1:0]  presc_sel;
  logic [2:0]  irq_en;
  logic        flag_clr_we;
  logic [2:0]  flag_clr_data;
  logic [2:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [2:0]  flags;
  logic        irq;
  logic [15:0] tcnt;

  int checks = 0;
  int errors = 0;
  logic [15:0] expcap [3];

  always #(CLK_P/2) clk = ~clk;

  icu_capture_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .edge_ctl(edge_ctl),
    .presc_sel(presc_sel), .irq_en(irq_en), .flag_clr_we(flag_clr_we),
    .flag_clr_data(flag_clr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flags(flags), .irq(irq), .tcnt(tcnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic rd_word(input int ch, output logic [15:0] w);
    rd_addr = 3'(2 * (ch - 1));
    #1 w[15:8] = rd_data;
    rd_addr = 3'(2 * (ch - 1) + 1);
    #1 w[7:0] = rd_data;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    flag_clr_we = 1'b1; flag_clr_data = m;
    step(1);
    flag_clr_we = 1'b0; flag_clr_data = '0;
  endtask

  initial begin
    step(200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w, tc, t0;
    rst_n = 1'b0; pin_async = 3'b111; edge_ctl = 8'h15; presc_sel = 2'd0;
    irq_en = 3'b111; flag_clr_we = 1'b0; flag_clr_data = '0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 tcnt", 32'(tcnt), 0);
    chk("R10 flags", 32'(flags), 0);
    for (int c = 1; c <= 3; c++) begin
      rd_word(c, w);
      chk("R10 capture", 32'(w), 0);
    end
    // R10: pins held high look like a rising edge after release
    step(2);
    tc = tcnt;
    chk("R1 R10 no flag yet", 32'(flags), 0);
    step(1);
    chk("R10 rise after reset", 32'(flags), 3'b111);
    for (int b = 0; b < 3; b++) expcap[b] = tc;
    for (int c = 1; c <= 3; c++) begin
      rd_word(c, w);
      chk("R4 R10 capture value", 32'(w), 32'(tc));
    end
    // R3 unused addresses
    rd_addr = 3'd6; #1 chk("R3 addr6", 32'(rd_data), 0);
    rd_addr = 3'd7; #1 chk("R3 addr7", 32'(rd_data), 0);

    // R2 sweep: every bit, code and direction
    for (int b = 0; b < 3; b++) begin
      for (int code = 0; code < 4; code++) begin
        for (int rise = 0; rise < 2; rise++) begin
          logic hit;
          edge_ctl = '0;
          pin_async[b] = (rise == 0);
          step(4);
          clear_flags(3'b111);
          edge_ctl[2*b +: 2] = 2'(code);
          pin_async[b] = (rise == 1);
          step(2);
          tc = tcnt;
          chk("R1 latency", 32'(flags), 0);
          step(1);
          hit = (code == 3) || (code == 1 && rise == 1) || (code == 2 && rise == 0);
          chk("R2 R5 flag", 32'(flags), hit ? (32'd1 << b) : 0);
          chk("R7 irq", 32'(irq), 32'(hit));
          if (hit) expcap[b] = tc;
          rd_word(3 - b, w);
          chk("R3 R4 capture", 32'(w), 32'(expcap[b]));
          step(3);
          chk("R2 R5 held level", 32'(flags), hit ? (32'd1 << b) : 0);
        end
      end
    end

    // R7 masking and R6 partial clear
    clear_flags(3'b111);
    edge_ctl = 8'h3F; irq_en = 3'b010;
    pin_async[0] = ~pin_async[0];
    step(4);
    chk("R7 masked", 32'(irq), 0);
    pin_async[1] = ~pin_async[1];
    step(4);
    chk("R7 enabled", 32'(irq), 1);
    clear_flags(3'b010);
    chk("R6 partial clear", 32'(flags), 3'b001);
    chk("R7 after clear", 32'(irq), 0);

    // R6 capture wins over clear at the same edge
    clear_flags(3'b111);
    pin_async[2] = ~pin_async[2];
    step(2);
    flag_clr_we = 1'b1; flag_clr_data = 3'b100;
    step(1);
    flag_clr_we = 1'b0; flag_clr_data = '0;
    chk("R6 capture wins", 32'(flags[2]), 1);
    clear_flags(3'b100);
    chk("R6 clear", 32'(flags[2]), 0);

    // R8 prescaler rates
    for (int s = 0; s < 4; s++) begin
      int d;
      d = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
      presc_sel = 2'(s);
      step(20);
      t0 = tcnt;
      step(64);
      chk("R8 rate", 32'(16'(tcnt - t0)), 32'(64 / d));
    end

    // R9 wrap
    presc_sel = 2'd0;
    while (tcnt != 16'hFFFF) step(1);
    step(1);
    chk("R9 wrap", 32'(tcnt), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule